// File: doc/BRIEF.md
# Cache Clean-and-Invalidate Access Gate

This block sits beside a core's system-instruction decoder and handles one access: the data-cache clean-and-invalidate operation that works on an address and reaches the point of physical storage. For each decode strobe it checks the instruction fields and the privilege and control state. It then decides, in a fixed priority order, whether the access is undefined, traps to EL2, is performed, or is not this instruction at all. It gives one registered outcome per accepted strobe. A performed access becomes a maintenance request to the cache port, and that request carries the 64-bit operand address.

The request leaves through a valid/ready channel. Once `req_valid` rises, it stays high and `req_addr` holds its value until the cache port samples `req_ready` high on a rising edge. This is the only back-pressure in the block. While a request is waiting, `in_ready` is low and any decode strobe is ignored. The request carries no encryption context identifier. The cache port tags each write-back with the context identifier stored with the line it evicts. Address translation, the cache and exception entry are handled elsewhere.

Top module: `cmo_access_gate`

## Requirements
- R1: The access matches only when op0=2'b01, op1=3'b000, crn=4'b0111, crm=4'b1111 and op2=3'b001. On any other encoding the outcome is `out_nomatch` alone and no request is raised.
- R2: For a matching access, if `feat_phys_store` or `feat_a64` is 0, the outcome is undefined at every exception level.
- R3: A matching access with the features present and `cur_el`=0 (EL0) is undefined.
- R4: At `cur_el`=1, if `el2_enabled` and `hyp_cmo_trap` are both 1, the access traps to EL2. This check takes priority over the fine-grained check.
- R5: At `cur_el`=1, if R4 does not apply, the access also traps when `el2_enabled`=1, `feat_fgt2`=1, and either (`el3_present`=1 and `mon_fgt2_en`=0) or `fgt_cmo_allow`=0.
- R6: A matching access is performed when none of R2 to R5 applies at `cur_el`=1, and always when `cur_el` is 2 or 3.
- R7: The outcome appears one cycle after an accepted strobe (`in_valid` and `in_ready` both high at a rising edge). It shows as `out_valid` for one cycle with exactly one of {undef, trap, perform, nomatch} set. `out_trap_class` is 6'h18 with a trap and 0 otherwise. All flags are 0 when `out_valid` is 0.
- R8: A performed access raises `req_valid` in the same cycle as its outcome. `req_addr` equals the operand address bit for bit, with no alignment check. Valid and address hold until `req_ready` is sampled high.
- R9: `in_ready` is 0 while a request is waiting. Strobes in that time give no outcome and do not change the request.
- R10: After reset, `out_valid`, every outcome flag, `out_trap_class` and `req_valid` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decode strobe |
| in_ready | output | 1 | Strobe is accepted when high |
| op0 | input | 2 | Instruction field op0 |
| op1 | input | 3 | Instruction field op1 |
| crn | input | 4 | Instruction field CRn |
| crm | input | 4 | Instruction field CRm |
| op2 | input | 3 | Instruction field op2 |
| xt_value | input | 64 | Operand register value (virtual address) |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| feat_phys_store | input | 1 | Physical-storage maintenance feature present |
| feat_a64 | input | 1 | 64-bit execution state present |
| feat_fgt2 | input | 1 | Second fine-grained trap feature present |
| el2_enabled | input | 1 | EL2 enabled in the current security state |
| el3_present | input | 1 | EL3 implemented |
| hyp_cmo_trap | input | 1 | Hypervisor coarse trap of this maintenance group |
| mon_fgt2_en | input | 1 | Monitor enable for the second fine-grained trap set |
| fgt_cmo_allow | input | 1 | Per-instruction fine-grained enable (0 traps) |
| out_valid | output | 1 | Outcome strobe |
| out_undef | output | 1 | Outcome: undefined |
| out_trap | output | 1 | Outcome: trap to EL2 |
| out_perform | output | 1 | Outcome: operation performed |
| out_nomatch | output | 1 | Outcome: encoding not this instruction |
| out_trap_class | output | 6 | Syndrome class of the trap |
| req_valid | output | 1 | Maintenance request valid |
| req_ready | input | 1 | Cache port accepts the request |
| req_addr | output | 64 | Maintenance request address |

## Verification
The bench drives priority collisions. In one, the coarse and fine traps apply together, and a gate with the wrong order would still trap but on the wrong rule. Other cases are missing features at EL2/EL3, where a gate that checked the level first would perform an undefined access, and EL3 enablement low while the per-instruction enable is high, where a gate missing that term would perform instead of trap. It holds `req_ready` low with strobes still arriving: a port that dropped valid early, let the address move or accepted a new decode would differ from the reference model on that clock. Unaligned and all-ones addresses catch any masking of low bits, and single-field encoding mismatches catch a loose match.

// File: rtl/cmo_gate_pkg.sv
package cmo_gate_pkg;

  typedef enum logic [1:0] {
    OUT_UNDEF   = 2'd0,
    OUT_TRAP    = 2'd1,
    OUT_PERFORM = 2'd2,
    OUT_NOMATCH = 2'd3
  } cmo_outcome_e;

  typedef struct packed {
    logic [1:0] el;
    logic       feat_store;
    logic       feat_a64;
    logic       feat_fgt2;
    logic       el2_en;
    logic       el3_present;
    logic       hyp_trap;
    logic       mon_fgt_en;
    logic       fgt_allow;
  } cmo_ctrl_t;

  localparam logic [1:0] LVL_EL0 = 2'd0;
  localparam logic [1:0] LVL_EL1 = 2'd1;

endpackage

// File: rtl/cmo_encoding_match.sv
module cmo_encoding_match #(
  parameter int unsigned OP0_W = 2,
  parameter int unsigned OP1_W = 3,
  parameter int unsigned CRN_W = 4,
  parameter int unsigned CRM_W = 4,
  parameter int unsigned OP2_W = 3,
  parameter logic [OP0_W-1:0] OP0_VAL = 2'b01,
  parameter logic [OP1_W-1:0] OP1_VAL = 3'b000,
  parameter logic [CRN_W-1:0] CRN_VAL = 4'b0111,
  parameter logic [CRM_W-1:0] CRM_VAL = 4'b1111,
  parameter logic [OP2_W-1:0] OP2_VAL = 3'b001
) (
  input  logic [OP0_W-1:0] op0,
  input  logic [OP1_W-1:0] op1,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             hit
);
  localparam int unsigned NFIELD = 5;
  logic [NFIELD-1:0] field_eq;

  always_comb begin
    field_eq[0] = (op0 == OP0_VAL);
    field_eq[1] = (op1 == OP1_VAL);
    field_eq[2] = (crn == CRN_VAL);
    field_eq[3] = (crm == CRM_VAL);
    field_eq[4] = (op2 == OP2_VAL);
    hit = &field_eq;
  end
endmodule

// File: rtl/cmo_priority_resolve.sv
module cmo_priority_resolve
  import cmo_gate_pkg::*;
(
  input  logic         hit,
  input  cmo_ctrl_t    ctrl,
  output cmo_outcome_e outcome
);
  logic feat_ok;
  logic coarse_trap;
  logic fine_trap;

  always_comb begin
    feat_ok     = ctrl.feat_store & ctrl.feat_a64;
    coarse_trap = ctrl.el2_en & ctrl.hyp_trap;
    fine_trap   = ctrl.el2_en & ctrl.feat_fgt2 &
                  ((ctrl.el3_present & ~ctrl.mon_fgt_en) | ~ctrl.fgt_allow);
    if (!hit)                     outcome = OUT_NOMATCH;
    else if (!feat_ok)            outcome = OUT_UNDEF;
    else if (ctrl.el == LVL_EL0)  outcome = OUT_UNDEF;
    else if (ctrl.el == LVL_EL1) begin
      if (coarse_trap)            outcome = OUT_TRAP;
      else if (fine_trap)         outcome = OUT_TRAP;
      else                        outcome = OUT_PERFORM;
    end
    else                          outcome = OUT_PERFORM;
  end
endmodule

// File: rtl/cmo_req_port.sv
module cmo_req_port #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
    end else if (load) begin
      req_valid <= 1'b1;
      req_addr  <= load_addr;
    end else if (req_valid && req_ready) begin
      req_valid <= 1'b0;
    end
  end

  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  p_addr_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> req_valid && req_addr == $past(load_addr));

  p_no_overload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |-> !load);
endmodule

// File: rtl/cmo_access_gate.sv
module cmo_access_gate
  import cmo_gate_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned CLASS_W    = 6,
  parameter logic [CLASS_W-1:0] TRAP_CLASS = 6'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         op0,
  input  logic [2:0]         op1,
  input  logic [3:0]         crn,
  input  logic [3:0]         crm,
  input  logic [2:0]         op2,
  input  logic [ADDR_W-1:0]  xt_value,
  input  logic [1:0]         cur_el,
  input  logic               feat_phys_store,
  input  logic               feat_a64,
  input  logic               feat_fgt2,
  input  logic               el2_enabled,
  input  logic               el3_present,
  input  logic               hyp_cmo_trap,
  input  logic               mon_fgt2_en,
  input  logic               fgt_cmo_allow,
  output logic               out_valid,
  output logic               out_undef,
  output logic               out_trap,
  output logic               out_perform,
  output logic               out_nomatch,
  output logic [CLASS_W-1:0] out_trap_class,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr
);
  logic         enc_hit;
  cmo_ctrl_t    ctrl;
  cmo_outcome_e outcome;
  logic         accept;
  logic         load_req;

  cmo_encoding_match u_match (
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2), .hit(enc_hit)
  );

  always_comb begin
    ctrl.el          = cur_el;
    ctrl.feat_store  = feat_phys_store;
    ctrl.feat_a64    = feat_a64;
    ctrl.feat_fgt2   = feat_fgt2;
    ctrl.el2_en      = el2_enabled;
    ctrl.el3_present = el3_present;
    ctrl.hyp_trap    = hyp_cmo_trap;
    ctrl.mon_fgt_en  = mon_fgt2_en;
    ctrl.fgt_allow   = fgt_cmo_allow;
  end

  cmo_priority_resolve u_resolve (
    .hit(enc_hit), .ctrl(ctrl), .outcome(outcome)
  );

  assign in_ready = ~req_valid;
  assign accept   = in_valid & in_ready;
  assign load_req = accept & (outcome == OUT_PERFORM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_undef      <= 1'b0;
      out_trap       <= 1'b0;
      out_perform    <= 1'b0;
      out_nomatch    <= 1'b0;
      out_trap_class <= '0;
    end else begin
      out_valid      <= accept;
      out_undef      <= accept & (outcome == OUT_UNDEF);
      out_trap       <= accept & (outcome == OUT_TRAP);
      out_perform    <= accept & (outcome == OUT_PERFORM);
      out_nomatch    <= accept & (outcome == OUT_NOMATCH);
      out_trap_class <= (accept && outcome == OUT_TRAP) ? TRAP_CLASS : '0;
    end
  end

  cmo_req_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .load(load_req), .load_addr(xt_value),
    .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr)
  );

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_undef, out_trap, out_perform, out_nomatch}) == 1);

  p_idle_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> {out_undef, out_trap, out_perform, out_nomatch} == 4'b0 && out_trap_class == '0);

  p_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap |-> out_trap_class == TRAP_CLASS);

  p_nomatch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !enc_hit |=> out_nomatch && !req_valid);

  p_feature_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && enc_hit && !(feat_phys_store && feat_a64) |=> out_undef);

  p_el0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && enc_hit && cur_el == 2'd0 |=> out_undef);

  p_coarse_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && enc_hit && feat_phys_store && feat_a64 && cur_el == 2'd1 &&
    el2_enabled && hyp_cmo_trap |=> out_trap);

  p_perform_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_perform |-> req_valid);

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !out_valid);
endmodule

// File: tb/tb_cmo_access_gate.sv
module tb_cmo_access_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic in_valid = 0, in_ready;
  logic [1:0] op0 = 0; logic [2:0] op1 = 0; logic [3:0] crn = 0, crm = 0; logic [2:0] op2 = 0;
  logic [63:0] xt_value = 0;
  logic [1:0] cur_el = 0;
  logic feat_phys_store = 0, feat_a64 = 0, feat_fgt2 = 0, el2_enabled = 0, el3_present = 0;
  logic hyp_cmo_trap = 0, mon_fgt2_en = 0, fgt_cmo_allow = 0;
  logic out_valid, out_undef, out_trap, out_perform, out_nomatch;
  logic [5:0] out_trap_class;
  logic req_valid, req_ready = 0;
  logic [63:0] req_addr;

  cmo_access_gate dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit          m_ov, m_rv;
  bit [3:0]    m_flags;   // {undef, trap, perform, nomatch}
  bit [5:0]    m_cls;
  bit [63:0]   m_addr;
  string       m_tag = "R10";

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int decide(output string tag);
    bit hit = (op0 == 2'b01) && (op1 == 3'b000) && (crn == 4'b0111) &&
              (crm == 4'b1111) && (op2 == 3'b001);
    if (!hit) begin tag = "R1"; return 3; end
    if (!feat_phys_store || !feat_a64) begin tag = "R2"; return 0; end
    if (cur_el == 0) begin tag = "R3"; return 0; end
    if (cur_el == 1) begin
      if (el2_enabled && hyp_cmo_trap) begin tag = "R4"; return 1; end
      if (el2_enabled && feat_fgt2 && ((el3_present && !mon_fgt2_en) || !fgt_cmo_allow)) begin
        tag = "R5"; return 1;
      end
    end
    tag = "R6"; return 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ov = 0; m_rv = 0; m_flags = 0; m_cls = 0; m_addr = 0; m_tag = "R10";
    end else begin
      bit acc;
      acc = in_valid && !m_rv;
      if (m_rv && req_ready) m_rv = 0;
      m_ov = acc; m_flags = 0; m_cls = 0;
      if (acc) begin
        string t;
        int o;
        o = decide(t);
        m_tag = t;
        m_flags[3 - o] = 1'b1;
        if (o == 1) m_cls = 6'h18;
        if (o == 2) begin m_rv = 1; m_addr = xt_value; end
      end else m_tag = "R9";
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(out_valid == m_ov, "R7", "out_valid", 64'(out_valid), 64'(m_ov));
    chk({out_undef, out_trap, out_perform, out_nomatch} == m_flags, m_tag, "flags",
        64'({out_undef, out_trap, out_perform, out_nomatch}), 64'(m_flags));
    chk(out_trap_class == m_cls, "R7", "class", 64'(out_trap_class), 64'(m_cls));
    chk(req_valid == m_rv, "R8", "req_valid", 64'(req_valid), 64'(m_rv));
    if (m_rv) chk(req_addr == m_addr, "R8", "req_addr", req_addr, m_addr);
    chk(in_ready == !m_rv, "R9", "in_ready", 64'(in_ready), 64'(!m_rv));
  end

  task automatic set_match();
    op0 = 2'b01; op1 = 3'b000; crn = 4'b0111; crm = 4'b1111; op2 = 3'b001;
  endtask

  // ctl = {fs, fa, fg, e2, e3, hyp, mon, allow}
  task automatic access(logic [1:0] el, logic [7:0] ctl, logic [63:0] a);
    @(posedge clk); #2;
    {feat_phys_store, feat_a64, feat_fgt2, el2_enabled, el3_present,
     hyp_cmo_trap, mon_fgt2_en, fgt_cmo_allow} = ctl;
    cur_el = el; xt_value = a; in_valid = 1;
    @(posedge clk); #2; in_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R10 reset state
    chk({out_valid, out_undef, out_trap, out_perform, out_nomatch} == 5'b0, "R10", "outputs in reset",
        64'({out_valid, out_undef, out_trap, out_perform, out_nomatch}), 64'd0);
    chk(req_valid == 0 && in_ready == 1 && out_trap_class == 0, "R10", "port in reset",
        64'({req_valid, in_ready}), 64'b01);
    @(negedge clk); rst_n = 1;
    req_ready = 1;
    set_match();
    access(2'd2, 8'b1111_1101, 64'h0000_0000_0000_1003);   // R6 unaligned at EL2
    access(2'd3, 8'b1100_0000, 64'hFFFF_FFFF_FFFF_FFFF);   // R6 EL3
    access(2'd2, 8'b0111_1111, 64'h1);                     // R2 at EL2
    access(2'd3, 8'b1011_1111, 64'h2);                     // R2 at EL3
    access(2'd0, 8'b1111_1111, 64'h3);                     // R3
    access(2'd1, 8'b1111_1110, 64'h4);                     // R4 with fine also set
    access(2'd1, 8'b1111_1001, 64'h5);                     // R5 via monitor bit
    access(2'd1, 8'b1111_0010, 64'h6);                     // R5 via per-instr bit
    access(2'd1, 8'b1101_0010, 64'h7);                     // R6 fgt2 absent
    access(2'd1, 8'b1110_1110, 64'h8);                     // R6 el2 disabled
    access(2'd1, 8'b1111_0011, 64'h9);                     // R6 no trap
    crm = 4'b1110;
    access(2'd3, 8'b1100_0000, 64'hA);                     // R1 nomatch
    set_match(); op2 = 3'b000;
    access(2'd2, 8'b0000_0000, 64'hB);                     // R1 nomatch beats R2
    set_match();
    // R8/R9 back-pressure with strobes arriving
    req_ready = 0;
    access(2'd2, 8'b1100_0000, 64'hDEAD_BEEF_0000_0007);
    @(posedge clk); #2; in_valid = 1; xt_value = 64'h1234; cur_el = 0;
    repeat (5) @(posedge clk);
    #2; req_ready = 1; in_valid = 0;
    repeat (2) @(posedge clk);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      in_valid = $urandom_range(0, 1);
      req_ready = ($urandom_range(0, 2) != 0);
      set_match();
      if ($urandom_range(0, 5) == 0) begin
        case ($urandom_range(0, 4))
          0: op0 = ~op0; 1: op1 = 3'b100; 2: crn = 4'b0110; 3: crm = 4'b0111; default: op2 = 3'b011;
        endcase
      end
      cur_el = 2'($urandom_range(0, 3));
      {feat_fgt2, el2_enabled, el3_present, hyp_cmo_trap, mon_fgt2_en, fgt_cmo_allow} = 6'($urandom);
      feat_phys_store = ($urandom_range(0, 7) != 0);
      feat_a64 = ($urandom_range(0, 7) != 0);
      xt_value = {$urandom, $urandom};
    end
    @(posedge clk); #2; in_valid = 0; req_ready = 1;
    repeat (4) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule